// File: doc/BRIEF.md
# Stream Link FIFO Interrupt Controller

This block raises two global interrupt requests, one for receive links and one for transmit links, from the FIFO status flags of up to eight receive and eight transmit stream links. Each link has its own enable bit and its own condition-select bit. A request is raised when an enabled link's selected condition turns true. It then stays pending until software acknowledges it through a defined register access, or until the module is disabled.

The block sits beside the link FIFOs. It sees their empty, full and at-least-half-full flags, plus single-cycle strobes that mark register accesses. It holds the 32-bit interrupt configuration register and presents a read-only status word of per-link half-full flags. The FIFOs and the data path are outside it.

Top module: `stream_link_irq_ctrl`

## Requirements
- R1: The configuration register reads back the last written value on the cycle after the write. Receive enables are in bits 31:24 and receive mode bits in 23:16. Transmit enables are in bits 15:8 and transmit mode bits in 7:0. Within each field, bit n belongs to link n. Bits of links that are not built read zero. Reset value is zero.
- R2: A receive link with mode bit 1 raises the receive request on the clock after its empty flag goes from 1 to 0.
- R3: A receive link with mode bit 0 raises the receive request on the clock after its half-full flag goes from 0 to 1.
- R4: A transmit link with mode bit 1 raises the transmit request on the clock after its full flag goes from 1 to 0.
- R5: A transmit link with mode bit 0 raises the transmit request on the clock after its half-full flag goes from 1 to 0.
- R6: A link whose enable bit is 0 never raises a request.
- R7: While the module enable input is low, both requests are 0 on the next clock and no request can be raised.
- R8: A pending receive request is cleared by a data-read strobe or a control-write strobe. A data-write strobe leaves it pending.
- R9: A pending transmit request is cleared by a data-write strobe or a control-write strobe. A data-read strobe leaves it pending.
- R10: If a raise event and a clearing strobe fall in the same cycle, the request is pending afterwards.
- R11: With a receive FIFO depth of 1, every receive mode bit reads 1. With a transmit FIFO depth of 1, every transmit mode bit reads 1.
- R12: The status word carries the transmit half-full flags in bits 31:24 and the receive half-full flags in bits 23:16. All other bits are zero.
- R13: A pending request is not tied to the level of its condition. It stays set after the condition goes false. A condition that stays true does not raise the request again after it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Module enable |
| cfg_we_i | input | 1 | Write strobe for the configuration register |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration register read value |
| ctrl_we_i | input | 1 | Strobe for a write to the control register |
| data_rd_i | input | 1 | Strobe for a read of any link data register |
| data_wr_i | input | 1 | Strobe for a write to any link data register |
| rx_empty_i | input | NUM_RX | Receive FIFO empty flags |
| rx_half_i | input | NUM_RX | Receive FIFO at-least-half-full flags |
| tx_full_i | input | NUM_TX | Transmit FIFO full flags |
| tx_half_i | input | NUM_TX | Transmit FIFO at-least-half-full flags |
| status_o | output | 32 | Half-full status word |
| rx_irq_o | output | 1 | Global receive interrupt request |
| tx_irq_o | output | 1 | Global transmit interrupt request |

## Verification
The assertions check these rules on every cycle:
- the disable rule and the set-over-clear priority;
- that a request holds its value when nothing touches it;
- that a link with all enables off produces no event;
- the configuration readback.

Only the bench's scenarios show the rest:
- which flag transition each mode selects;
- that the read and write strobes each clear only their own side;
- that a condition held true fires only once.

A depth-1 instance shows the forced mode bits.

// File: rtl/slk_pkg.sv
package slk_pkg;
  localparam int unsigned MAX_LINKS = 8;

  typedef struct packed {
    logic [MAX_LINKS-1:0] rx_en;
    logic [MAX_LINKS-1:0] rx_mode;
    logic [MAX_LINKS-1:0] tx_en;
    logic [MAX_LINKS-1:0] tx_mode;
  } slk_cfg_t;
endpackage

// File: rtl/slk_cfg_reg.sv
module slk_cfg_reg
  import slk_pkg::*;
#(
  parameter int unsigned NUM_RX   = 8,
  parameter int unsigned NUM_TX   = 8,
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned TX_DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output slk_cfg_t    cfg_o,
  output logic [31:0] rdata_o
);
  localparam logic [MAX_LINKS-1:0] RX_MASK = MAX_LINKS'((1 << NUM_RX) - 1);
  localparam logic [MAX_LINKS-1:0] TX_MASK = MAX_LINKS'((1 << NUM_TX) - 1);

  slk_cfg_t cfg_q, wr_cfg;

  assign wr_cfg = slk_cfg_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.rx_en   <= wr_cfg.rx_en   & RX_MASK;
      cfg_q.rx_mode <= wr_cfg.rx_mode & RX_MASK;
      cfg_q.tx_en   <= wr_cfg.tx_en   & TX_MASK;
      cfg_q.tx_mode <= wr_cfg.tx_mode & TX_MASK;
    end
  end

  assign cfg_o.rx_en = cfg_q.rx_en;
  assign cfg_o.tx_en = cfg_q.tx_en;

  // single-entry FIFO: only the "any entry" conditions make sense
  generate
    if (RX_DEPTH == 1) begin : g_rx_fixed
      assign cfg_o.rx_mode = RX_MASK;
    end else begin : g_rx_prog
      assign cfg_o.rx_mode = cfg_q.rx_mode;
    end
    if (TX_DEPTH == 1) begin : g_tx_fixed
      assign cfg_o.tx_mode = TX_MASK;
    end else begin : g_tx_prog
      assign cfg_o.tx_mode = cfg_q.tx_mode;
    end
  endgenerate

  assign rdata_o = 32'(cfg_o);

  // R1
  cfg_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[31:24] == ($past(wdata_i[31:24]) & RX_MASK)) &&
             (rdata_o[15:8]  == ($past(wdata_i[15:8])  & TX_MASK)));
endmodule

// File: rtl/slk_cond_edge.sv
module slk_cond_edge #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] en_i,
  output logic         event_o
);
  logic [N-1:0] cond_q;
  logic [N-1:0] rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= '0;
    else         cond_q <= cond_i;
  end

  assign rise    = cond_i & ~cond_q & en_i;
  assign event_o = |rise;

  // R6
  no_event_when_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !event_o);
endmodule

// File: rtl/slk_pending.sv
module slk_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_o <= 1'b0;
    else if (!enable_i) pend_o <= 1'b0;
    else if (set_i)     pend_o <= 1'b1;
    else if (clr_i)     pend_o <= 1'b0;
  end

  // R7
  off_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !pend_o);
  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && set_i) |=> pend_o);
  // R8
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && clr_i && !set_i) |=> !pend_o);
  // R13
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !set_i && !clr_i) |=> (pend_o == $past(pend_o)));
endmodule

// File: rtl/stream_link_irq_ctrl.sv
module stream_link_irq_ctrl
  import slk_pkg::*;
#(
  parameter int unsigned NUM_RX   = 8,
  parameter int unsigned NUM_TX   = 8,
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned TX_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              ctrl_we_i,
  input  logic              data_rd_i,
  input  logic              data_wr_i,
  input  logic [NUM_RX-1:0] rx_empty_i,
  input  logic [NUM_RX-1:0] rx_half_i,
  input  logic [NUM_TX-1:0] tx_full_i,
  input  logic [NUM_TX-1:0] tx_half_i,
  output logic [31:0]       status_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);
  slk_cfg_t          cfg;
  logic [NUM_RX-1:0] rx_cond, rx_en, rx_mode;
  logic [NUM_TX-1:0] tx_cond, tx_en, tx_mode;
  logic              rx_event, tx_event;
  logic [7:0]        rx_half8, tx_half8;

  slk_cfg_reg #(
    .NUM_RX(NUM_RX), .NUM_TX(NUM_TX), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)
  ) i_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg), .rdata_o(cfg_rdata_o)
  );

  assign rx_en   = cfg.rx_en[NUM_RX-1:0];
  assign rx_mode = cfg.rx_mode[NUM_RX-1:0];
  assign tx_en   = cfg.tx_en[NUM_TX-1:0];
  assign tx_mode = cfg.tx_mode[NUM_TX-1:0];

  // mode 1: not empty / not full; mode 0: at least half / below half
  assign rx_cond = (rx_mode & ~rx_empty_i) | (~rx_mode & rx_half_i);
  assign tx_cond = (tx_mode & ~tx_full_i)  | (~tx_mode & ~tx_half_i);

  slk_cond_edge #(.N(NUM_RX)) i_rx_edge (
    .clk_i, .rst_ni, .cond_i(rx_cond), .en_i(rx_en), .event_o(rx_event)
  );
  slk_cond_edge #(.N(NUM_TX)) i_tx_edge (
    .clk_i, .rst_ni, .cond_i(tx_cond), .en_i(tx_en), .event_o(tx_event)
  );

  slk_pending i_rx_pend (
    .clk_i, .rst_ni, .enable_i, .set_i(rx_event),
    .clr_i(data_rd_i | ctrl_we_i), .pend_o(rx_irq_o)
  );
  slk_pending i_tx_pend (
    .clk_i, .rst_ni, .enable_i, .set_i(tx_event),
    .clr_i(data_wr_i | ctrl_we_i), .pend_o(tx_irq_o)
  );

  always_comb begin
    rx_half8 = '0;
    tx_half8 = '0;
    rx_half8[NUM_RX-1:0] = rx_half_i;
    tx_half8[NUM_TX-1:0] = tx_half_i;
  end

  assign status_o = {tx_half8, rx_half8, 16'h0000};

  // R12
  status_layout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[15:0] == 16'h0000) && (status_o[23:16] == 8'(rx_half_i)));
endmodule

// File: tb/test_stream_link_irq_ctrl.sv
module test_stream_link_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        ctrl_we = 1'b0, data_rd = 1'b0, data_wr = 1'b0;
  logic [7:0]  rx_empty = 8'hFF, rx_half = 8'h00, tx_full = 8'h00, tx_half = 8'h00;
  logic [31:0] cfg_rdata, status, cfg_rdata_d1, status_d1;
  logic        rx_irq, tx_irq, rx_irq_d1, tx_irq_d1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_cfg = '0;
  logic [7:0]  m_prev_rx = '0, m_prev_tx = '0;
  logic        m_rx = 1'b0, m_tx = 1'b0;

  always #5 clk = ~clk;

  stream_link_irq_ctrl i_stream_link_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .ctrl_we_i(ctrl_we),
    .data_rd_i(data_rd), .data_wr_i(data_wr), .rx_empty_i(rx_empty),
    .rx_half_i(rx_half), .tx_full_i(tx_full), .tx_half_i(tx_half),
    .status_o(status), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  stream_link_irq_ctrl #(.RX_DEPTH(1), .TX_DEPTH(1)) i_stream_link_irq_ctrl_d1 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata_d1), .ctrl_we_i(ctrl_we),
    .data_rd_i(data_rd), .data_wr_i(data_wr), .rx_empty_i(rx_empty),
    .rx_half_i(rx_half), .tx_full_i(tx_full), .tx_half_i(tx_half),
    .status_o(status_d1), .rx_irq_o(rx_irq_d1), .tx_irq_o(tx_irq_d1)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic cyc(input string req);
    logic ev_rx, ev_tx, c;
    @(posedge clk);
    ev_rx = 1'b0;
    ev_tx = 1'b0;
    for (int i = 0; i < 8; i++) begin
      c = m_cfg[16+i] ? !rx_empty[i] : rx_half[i];
      if (m_cfg[24+i] && c && !m_prev_rx[i]) ev_rx = 1'b1;
      m_prev_rx[i] = c;
      c = m_cfg[i] ? !tx_full[i] : !tx_half[i];
      if (m_cfg[8+i] && c && !m_prev_tx[i]) ev_tx = 1'b1;
      m_prev_tx[i] = c;
    end
    if (!enable)             m_rx = 1'b0;
    else if (ev_rx)          m_rx = 1'b1;
    else if (data_rd || ctrl_we) m_rx = 1'b0;
    if (!enable)             m_tx = 1'b0;
    else if (ev_tx)          m_tx = 1'b1;
    else if (data_wr || ctrl_we) m_tx = 1'b0;
    if (cfg_we) m_cfg = cfg_wdata;
    @(negedge clk);
    chk(req, "rx_irq", 32'(rx_irq), 32'(m_rx));
    chk(req, "tx_irq", 32'(tx_irq), 32'(m_tx));
    chk("R1", "cfg_rdata", cfg_rdata, m_cfg);
    chk("R12", "status", status, {tx_half, rx_half, 16'h0});
    cfg_we = 1'b0; ctrl_we = 1'b0; data_rd = 1'b0; data_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "reset cfg", cfg_rdata, 32'h0);
    chk("R7", "reset irqs", {30'h0, rx_irq, tx_irq}, 32'h0);
    rst_n = 1'b1;
    cyc("R1");
    // enables links 0..3 both sides; rx modes: 0,2 -> 1; tx modes: 0,1 -> 1
    cfg_we = 1'b1; cfg_wdata = 32'h0F05_0F03; enable = 1'b1;
    cyc("R1");
    cyc("R1");
    chk("R1", "cfg readback", cfg_rdata, 32'h0F05_0F03);
    chk("R11", "depth1 modes forced", cfg_rdata_d1, 32'h0FFF_0FFF);
    // R2: link 0 becomes non-empty
    rx_empty[0] = 1'b0; cyc("R2");
    chk("R2", "rx irq on not-empty", 32'(rx_irq), 32'h1);
    data_wr = 1'b1; cyc("R8");
    chk("R8", "data write leaves rx", 32'(rx_irq), 32'h1);
    data_rd = 1'b1; cyc("R8");
    chk("R8", "data read clears rx", 32'(rx_irq), 32'h0);
    repeat (3) cyc("R13");
    chk("R13", "held condition no refire", 32'(rx_irq), 32'h0);
    // R3: link 1 mode 0 reaches half
    rx_empty[1] = 1'b0; cyc("R3");
    chk("R3", "not-empty ignored in mode 0", 32'(rx_irq), 32'h0);
    rx_half[1] = 1'b1; cyc("R3");
    chk("R3", "rx irq on half", 32'(rx_irq), 32'h1);
    ctrl_we = 1'b1; cyc("R8");
    chk("R8", "ctrl write clears rx", 32'(rx_irq), 32'h0);
    // R6: disabled links
    rx_half[5] = 1'b1; rx_empty[6] = 1'b0; tx_full[5] = 1'b1; cyc("R6");
    tx_full[5] = 1'b0; cyc("R6");
    chk("R6", "masked links", {30'h0, rx_irq, tx_irq}, 32'h0);
    // R4: tx link 0 full then not full
    tx_full[0] = 1'b1; cyc("R4");
    chk("R4", "full gives no tx irq", 32'(tx_irq), 32'h0);
    tx_full[0] = 1'b0; cyc("R4");
    chk("R4", "tx irq on not-full", 32'(tx_irq), 32'h1);
    data_rd = 1'b1; cyc("R9");
    chk("R9", "data read leaves tx", 32'(tx_irq), 32'h1);
    data_wr = 1'b1; cyc("R9");
    chk("R9", "data write clears tx", 32'(tx_irq), 32'h0);
    // R5: tx link 2 mode 0 falls below half
    tx_half[2] = 1'b1; cyc("R5");
    chk("R5", "rising half no tx irq", 32'(tx_irq), 32'h0);
    tx_half[2] = 1'b0; cyc("R5");
    chk("R5", "tx irq below half", 32'(tx_irq), 32'h1);
    ctrl_we = 1'b1; cyc("R9");
    chk("R9", "ctrl write clears tx", 32'(tx_irq), 32'h0);
    // R10: event and clear in the same cycle
    rx_empty[2] = 1'b0; data_rd = 1'b1; cyc("R10");
    chk("R10", "set beats clear", 32'(rx_irq), 32'h1);
    // R13: condition drops, request stays
    rx_empty[2] = 1'b1; cyc("R13");
    chk("R13", "pending after condition gone", 32'(rx_irq), 32'h1);
    // R7: disabling clears; no raise while disabled
    enable = 1'b0; cyc("R7");
    chk("R7", "disable clears", 32'(rx_irq), 32'h0);
    rx_empty[2] = 1'b0; tx_full[1] = 1'b1; cyc("R7");
    tx_full[1] = 1'b0; cyc("R7");
    chk("R7", "no raise while disabled", {30'h0, rx_irq, tx_irq}, 32'h0);
    enable = 1'b1; cyc("R7");
    chk("R7", "old edges not replayed", {30'h0, rx_irq, tx_irq}, 32'h0);
    // R12: status patterns
    rx_half = 8'hA5; tx_half = 8'h3C; cyc("R12");
    chk("R12", "status pattern", status, 32'h3CA5_0000);
    rx_half = 8'h00; tx_half = 8'hFF; cyc("R12");
    // R11: writing zero modes to the depth-1 instance
    cfg_we = 1'b1; cfg_wdata = 32'hFF00_FF00; cyc("R11");
    chk("R11", "depth1 modes read one", cfg_rdata_d1, 32'hFFFF_FFFF);
    chk("R1", "depth8 modes stored", cfg_rdata, 32'hFF00_FF00);
    repeat (3) cyc("R13");
    finish_run();
  end
endmodule